// File: doc/BRIEF.md
# Trigger-Windowed Sample Accumulator

This block sums a stream of unsigned 10-bit ADC codes over a measurement window. An external trigger line sets the window. The trigger comes from a device running on its own clock, so the block treats it as asynchronous. It first re-times the trigger into the sample clock domain. It then looks only at rising edges of the trigger.

A host arms the block with a command. The next trigger rise opens a window, and the rise after that closes it. Inside the window every valid sample is added to a wide sum, and a parallel counter records how many samples were taken. Once the window closes, the results stay frozen until the host re-arms the block or clears it. The host reads the results through a small register read port, which gives the sum, the count and a status word. From the sum and the count the host can work out the average level and the length of the window.

The block runs at the ADC sample rate, which may be as high as 30 MHz.

Top module: `trig_window_accum`

## Requirements
- R1: The trigger passes through two synchronising flops. A trigger rise that is first sampled high at clock edge k is acted on at edge k+2.
- R2: After reset the block is idle, with sum 0, count 0 and done low, and trigger edges have no effect. The arm command (cmd_op = 1 with cmd_valid) moves the block from idle or done to armed.
- R3: In the armed state, a trigger rise opens the window. At that edge the sum and the count restart from zero, and a valid sample present at that same edge is the first one included.
- R4: While the window is open, each valid sample adds its code to the sum and adds one to the count. Cycles without sample_valid change neither. The sum never exceeds 1023 times the count.
- R5: The next trigger rise closes the window. A sample present at the closing edge is not included, and done is high from the cycle after that edge.
- R6: In the done state, sum, count, done and the overflow flag stay stable. Trigger edges are ignored until a host command arrives.
- R7: The count saturates at 2^CNT_W-1. A valid sample that arrives while the count is at that value is added to neither the sum nor the count, and it sets the sticky overflow flag. The flag clears when the next window opens and when a clear command arrives.
- R8: The clear command (cmd_op = 2 with cmd_valid) returns the block to idle from any state and zeroes sum, count, done and overflow. It takes priority over a trigger edge in the same cycle.
- R9: A read request at edge k returns rd_valid and rd_data at edge k+1. Address 0 returns the status word, with bits [3:2] holding the state (idle 0, armed 1, accumulating 2, done 3), bit 1 the overflow flag and bit 0 done. Address 1 returns the count, address 2 the low 32 bits of the sum and address 3 the sum bits above 31.
- R10: Only rising trigger edges act. Holding the trigger high, or letting it fall, neither opens nor closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SMP_W (10) | Unsigned ADC code |
| smp_valid | input | 1 | Sample strobe |
| trig_async | input | 1 | Asynchronous window trigger |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command: 1 arm, 2 clear |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | Register address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | HOST_W (32) | Read data |
| sum_out | output | SMP_W+CNT_W (42) | Running or final sum |
| count_out | output | CNT_W (32) | Samples accumulated |
| done | output | 1 | Window closed, results held |
| cnt_ovf | output | 1 | Sticky count saturation flag |

## Verification
The trigger acts two clock edges after it is first sampled high. Sum and count change at the edge that consumes a sample. Done rises at the closing edge, and read data appears one edge after the request. A behavioural model in the bench takes in the same inputs at each rising edge, using a short history of trigger values. The bench compares every output with this model at the falling edge, once all registers have settled. Further checks, placed at the exact falling edges that follow the opening and closing edges, confirm the cycle in which the first sample lands. They also check that the sample present at the closing edge is dropped, and that a clear issued in the same cycle as a trigger edge wins.

// File: rtl/twa_pkg.sv
package twa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ACCUM = 2'd2,
    ST_DONE  = 2'd3
  } twa_state_e;

  localparam logic [1:0] OP_ARM   = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;

  localparam int unsigned RA_STATUS = 0;
  localparam int unsigned RA_COUNT  = 1;
  localparam int unsigned RA_SUM_LO = 2;
  localparam int unsigned RA_SUM_HI = 3;
endpackage

// File: rtl/twa_sync_edge.sv
module twa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              hist_q;

  // Synchroniser chain: stage 0 samples the asynchronous line.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~hist_q;

  // R10: a held level yields a single pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/twa_ctrl.sv
module twa_ctrl
  import twa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output twa_state_e state,
  output logic       done,
  output logic       clr,
  output logic       open_win,
  output logic       accum_en
);
  twa_state_e state_d;
  logic       arm;

  assign clr      = cmd_valid && (cmd_op == OP_CLEAR);
  assign arm      = cmd_valid && (cmd_op == OP_ARM);
  assign open_win = (state == ST_ARMED) && rise && !clr;
  assign accum_en = (state == ST_ACCUM) && !rise && !clr;

  always_comb begin
    state_d = state;
    if (clr) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (arm)  state_d = ST_ARMED;
        ST_ARMED: if (rise) state_d = ST_ACCUM;
        ST_ACCUM: if (rise) state_d = ST_DONE;
        ST_DONE:  if (arm)  state_d = ST_ARMED;
        default:            state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= (state_d == ST_DONE);
    end
  end

  // R2: idle only leaves towards armed
  a_r2_idle_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> (state == ST_IDLE) || (state == ST_ARMED));
  // R5: closing edge raises done
  a_r5_close_done: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ACCUM) && rise && !clr) |=> done);
  // R6: done holds without a command
  a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DONE) && !cmd_valid) |=> (state == ST_DONE) && done);
  // R8: clear always lands in idle
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clr |=> (state == ST_IDLE) && !done);
endmodule

// File: rtl/twa_accum.sv
module twa_accum #(
  parameter int SMP_W = 10,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   open_win,
  input  logic                   accum_en,
  input  logic                   smp_valid,
  input  logic [SMP_W-1:0]       smp_data,
  output logic [SMP_W+CNT_W-1:0] sum,
  output logic [CNT_W-1:0]       cnt,
  output logic                   ovf
);
  localparam int SUM_W = SMP_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUM_W-1:0] SMP_MAX = SUM_W'({SMP_W{1'b1}});

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (open_win) begin
      sum <= smp_valid ? SUM_W'(smp_data) : '0;
      cnt <= smp_valid ? CNT_W'(1) : '0;
      ovf <= 1'b0;
    end else if (accum_en && smp_valid) begin
      if (at_max) begin
        ovf <= 1'b1;
      end else begin
        sum <= sum + SUM_W'(smp_data);
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R3: a new window starts from at most one sample
  a_r3_open_fresh: assert property (@(posedge clk) disable iff (rst)
    (open_win && !clr) |=> (cnt <= CNT_W'(1)) && !ovf);
  // R4: the sum is bounded by the count times the largest code
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sum <= (SUM_W'(cnt) * SMP_MAX));
  // R7: a saturated count stays put inside the window
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (at_max && accum_en && smp_valid && !clr) |=> at_max && ovf && $stable(sum));
  // R8: clear zeroes the results
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && (sum == '0) && !ovf);
endmodule

// File: rtl/twa_host_port.sv
module twa_host_port
  import twa_pkg::*;
#(
  parameter int SUM_W  = 42,
  parameter int CNT_W  = 32,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  twa_state_e        state,
  input  logic              done,
  input  logic              ovf,
  input  logic [SUM_W-1:0]  sum,
  input  logic [CNT_W-1:0]  cnt,
  output logic              rd_valid,
  output logic [HOST_W-1:0] rd_data
);
  localparam int PAD_W = 2 * HOST_W;

  logic [PAD_W-1:0]  sum_pad;
  logic [HOST_W-1:0] mux;

  assign sum_pad = PAD_W'(sum);

  always_comb begin
    unique case (rd_addr)
      2'(RA_STATUS): mux = HOST_W'({state, ovf, done});
      2'(RA_COUNT):  mux = HOST_W'(cnt);
      2'(RA_SUM_LO): mux = sum_pad[HOST_W-1:0];
      default:       mux = sum_pad[PAD_W-1:HOST_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux;
    end
  end

  // R9: one-cycle read latency
  a_r9_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/trig_window_accum.sv
module trig_window_accum
  import twa_pkg::*;
#(
  parameter int SMP_W     = 10,
  parameter int CNT_W     = 32,
  parameter int HOST_W    = 32,
  parameter int SYNC_STGS = 2,
  localparam int SUM_W    = SMP_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              smp_valid,
  input  logic              trig_async,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic              rd_valid,
  output logic [HOST_W-1:0] rd_data,
  output logic [SUM_W-1:0]  sum_out,
  output logic [CNT_W-1:0]  count_out,
  output logic              done,
  output logic              cnt_ovf
);
  logic       rise;
  logic       clr;
  logic       open_win;
  logic       accum_en;
  twa_state_e state;

  twa_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (trig_async),
    .rise     (rise)
  );

  twa_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .state     (state),
    .done      (done),
    .clr       (clr),
    .open_win  (open_win),
    .accum_en  (accum_en)
  );

  twa_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .open_win  (open_win),
    .accum_en  (accum_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .sum       (sum_out),
    .cnt       (count_out),
    .ovf       (cnt_ovf)
  );

  twa_host_port #(.SUM_W(SUM_W), .CNT_W(CNT_W), .HOST_W(HOST_W)) u_host (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .state    (state),
    .done     (done),
    .ovf      (cnt_ovf),
    .sum      (sum_out),
    .cnt      (count_out),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R6: held results do not move while done and no command
  a_r6_results_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_valid) |=> $stable(sum_out) && $stable(count_out) && $stable(cnt_ovf));
endmodule

// File: tb/tb_trig_window_accum.sv
`timescale 1ns/1ps
module tb_trig_window_accum;
  localparam int SMP_W = 10;
  localparam int CNT_W = 4;
  localparam int HOST_W = 32;
  localparam int SUM_W = SMP_W + CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SMP_W-1:0] smp_data = '0;
  logic smp_valid = 1'b0;
  logic trig = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic rd_valid;
  logic [HOST_W-1:0] rd_data;
  logic [SUM_W-1:0] sum_out;
  logic [CNT_W-1:0] count_out;
  logic done, cnt_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trig_window_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W), .HOST_W(HOST_W)) dut (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .trig_async(trig), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .sum_out(sum_out), .count_out(count_out), .done(done), .cnt_ovf(cnt_ovf));

  // Behavioural reference model
  int unsigned m_state = 0;
  longint unsigned m_sum = 0;
  longint unsigned m_cnt = 0;
  bit m_ovf = 0;
  bit m_rv = 0;
  longint unsigned m_rd = 0;
  bit th[3] = '{0, 0, 0};
  longint unsigned cmax = (64'd1 << CNT_W) - 1;

  always @(posedge clk) begin
    bit edge_seen;
    if (rst) begin
      m_state = 0; m_sum = 0; m_cnt = 0; m_ovf = 0; m_rv = 0; m_rd = 0;
      th = '{0, 0, 0};
    end else begin
      edge_seen = th[1] && !th[2];
      th[2] = th[1]; th[1] = th[0]; th[0] = trig;
      m_rv = rd_en;
      if (rd_en) begin
        case (rd_addr)
          2'd0: m_rd = (m_state << 2) | (longint'(m_ovf) << 1) | longint'(m_state == 3);
          2'd1: m_rd = m_cnt;
          2'd2: m_rd = m_sum & 64'hFFFF_FFFF;
          default: m_rd = m_sum >> 32;
        endcase
      end
      if (cmd_valid && cmd_op == 2) begin
        m_state = 0; m_sum = 0; m_cnt = 0; m_ovf = 0;
      end else begin
        case (m_state)
          0: if (cmd_valid && cmd_op == 1) m_state = 1;
          1: if (edge_seen) begin
               m_state = 2; m_ovf = 0;
               m_sum = smp_valid ? longint'(smp_data) : 0;
               m_cnt = smp_valid ? 1 : 0;
             end
          2: if (edge_seen) m_state = 3;
             else if (smp_valid) begin
               if (m_cnt == cmax) m_ovf = 1;
               else begin m_sum += smp_data; m_cnt++; end
             end
          default: if (cmd_valid && cmd_op == 1) m_state = 1;
        endcase
      end
    end
  end

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4 sum", sum_out, m_sum);
      chk("R4 count", count_out, m_cnt);
      chk("R5 done", done, m_state == 3);
      chk("R7 ovf", cnt_ovf, m_ovf);
      chk("R9 rd_valid", rd_valid, m_rv);
      if (m_rv) chk("R9 rd_data", rd_data, m_rd);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    step(1);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output longint unsigned v);
    rd_en = 1'b1; rd_addr = a;
    step(1);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint unsigned v, hs, hc;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R2 reset sum", sum_out, 0);
    chk("R2 reset count", count_out, 0);
    chk("R2 reset done", done, 0);

    // Trigger while idle: ignored
    smp_valid = 1'b1; smp_data = 10'd77;
    trig = 1'b1; step(3); trig = 1'b0; step(4);
    chk("R2 idle ignores trigger count", count_out, 0);
    rd(2'd0, v);
    chk("R2 status idle", v, 0);

    cmd(2'd1);
    rd(2'd0, v);
    chk("R2 status armed", v, 4);

    // R1 timing of the opening edge
    smp_data = 10'd5;
    trig = 1'b1;
    step(1);
    chk("R1 no open at k", count_out, 0);
    step(1);
    chk("R1 no open at k+1", count_out, 0);
    step(1);
    chk("R1 open at k+2 count", count_out, 1);
    chk("R3 open sample included", sum_out, 5);
    for (int i = 0; i < 5; i++) begin
      smp_data = 10'(37 * i + 100);
      step(1);
    end
    chk("R10 held high stays open", done, 0);
    trig = 1'b0;
    for (int i = 0; i < 8; i++) begin
      smp_valid = (i % 3) != 0;
      smp_data = 10'(900 - 11 * i);
      step(1);
    end
    chk("R10 falling edge does not close", done, 0);
    // Close with a sample present at the closing edge
    smp_valid = 1'b1; smp_data = 10'd999;
    trig = 1'b1;
    step(2);
    hs = sum_out; hc = count_out;
    step(1);
    chk("R5 done after closing edge", done, 1);
    chk("R5 closing sample excluded sum", sum_out, hs);
    chk("R5 closing sample excluded count", count_out, hc);

    // R6: trigger edges in done are ignored
    trig = 1'b0; step(3); trig = 1'b1; step(3); trig = 1'b0; step(5);
    chk("R6 sum held", sum_out, hs);
    chk("R6 count held", count_out, hc);
    chk("R6 done held", done, 1);

    // R9 register map
    rd(2'd0, v); chk("R9 status done", v, 13 & ~(2)); // state 3, done 1
    rd(2'd1, v); chk("R9 count reg", v, hc);
    rd(2'd2, v); chk("R9 sum low", v, hs & 64'hFFFF_FFFF);
    rd(2'd3, v); chk("R9 sum high", v, hs >> 32);

    // R7 saturation
    cmd(2'd1);
    smp_valid = 1'b1; smp_data = 10'd1023;
    trig = 1'b1; step(22);
    chk("R7 count saturated", count_out, cmax);
    chk("R7 sum stops", sum_out, cmax * 1023);
    chk("R7 ovf set", cnt_ovf, 1);
    trig = 1'b0; step(3); trig = 1'b1; step(4);
    chk("R7 ovf sticky in done", cnt_ovf, 1);
    trig = 1'b0; step(3);
    cmd(2'd1);
    smp_data = 10'd3;
    trig = 1'b1; step(4);
    chk("R7 ovf clears on open", cnt_ovf, 0);
    chk("R3 fresh sum on new window", sum_out, 6);

    // R8 clear coinciding with the closing edge
    trig = 1'b0; step(3);
    trig = 1'b1; step(2);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    step(1);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    chk("R8 clear done", done, 0);
    chk("R8 clear sum", sum_out, 0);
    chk("R8 clear count", count_out, 0);
    rd(2'd0, v);
    chk("R8 status idle after clear", v, 0);
    smp_valid = 1'b0; trig = 1'b0;
    step(4);
    finish_run();
  end
endmodule